// File: doc/BRIEF.md
# Programmable Clock Output Divider Matrix

This block turns one selected source clock into six output clock pairs, twelve outputs in all. The source is either a stand-in for a PLL output or the reference clock. A shared divider bank is built from that source. It has fixed taps for divide by 1, 2, 3 and 4, programmable taps for divide by X and by 2X, a direct reference tap and a tap that carries a lock flag. Each pair picks one tap with its own 3-bit code. Each pair can also make its even output the complement of its odd output, and each pair can be released to high impedance through an output-enable signal.

The whole setup lives in four stored configuration sets, and a two-bit personality select chooses which set is live. Each set holds the pair enables, the divider-source bit and the six pair codes. When the configuration table is marked not valid, a fixed unprogrammed table is used in its place. Every counter in the divider bank restarts on the same cycle whenever the live set or X changes, so pairs that use the same tap stay in phase.

The source clocks and the lock flag are level inputs sampled by the system clock `clk`. Their rising edges act as the divider ticks, so each output toggles on a grid of whole `clk` cycles.

Top module: `clkmx_top`

## Requirements
- R1: While `rstN` is low, every bit of `clkOut` and `clkOe` is 0.
- R2: Code 000 outputs the reference clock, with its period and a 50% duty cycle, whatever the divider-source bit says. Code 001 outputs the selected source clock undivided, with its period and a 50% duty cycle.
- R3: Codes 010, 011 and 100 divide the selected source by 2, 3 and 4. For a ratio N the output period is N source periods. It stays high for ceil(N/2) source periods, which is exactly 50% for even N.
- R4: Code 101 divides by X and code 110 divides by 2X, with the same duty rule as R3. `xValue` is clamped into 5..130 before use.
- R5: Bit 18 of a set (the divider-source bit) feeds taps 001..110 from the reference clock when it is 1, and from the PLL stand-in when it is 0.
- R6: For pair p, `clkOut[2p+1]` carries the tap. `clkOut[2p]` equals it when `invEven[p]` is 0 and is its complement when `invEven[p]` is 1.
- R7: Code 111 drives the lock flag. The odd output equals `lockFlag`. The even output equals `lockFlag`, or its complement when that pair's inversion is on.
- R8: `cfgSel` picks set k = `cfgSel`. When `cfgValid` is 1, set k is `cfgTable[25k+24:25k]`. In that field, bits 24:19 are the pair enables (bit 19+p for pair p), bit 18 is the divider-source bit, and bits 3p+2:3p are the code of pair p. When `cfgValid` is 0, the table input is ignored and the unprogrammed sets apply, with all codes 010. Those sets are: 00, all pairs off, PLL source; 01, pairs 0 to 2 on, pairs 3 to 5 off, PLL source; 10, all on, reference source; 11, all on, PLL source.
- R9: An enabled pair drives `clkOe` high on both of its outputs. A disabled pair drives `clkOe` low and `clkOut` low on both of its outputs.
- R10: Enabled pairs with the same code have identical odd outputs on every cycle. All divider counters restart together on a set or X change, and the divider taps are low on the cycle after the restart strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the sources |
| rstN | input | 1 | Active-low synchronous reset |
| pllClk | input | 1 | PLL output stand-in, level input |
| refClk | input | 1 | Reference clock, level input |
| lockFlag | input | 1 | PLL lock indication |
| cfgSel | input | 2 | Personality select |
| cfgValid | input | 1 | 1: use cfgTable, 0: use unprogrammed sets |
| cfgTable | input | 100 | Four 25-bit configuration sets |
| invEven | input | 6 | Per-pair inversion of the even output |
| xValue | input | 8 | Programmable divide value X |
| clkOut | output | 12 | Output clocks, pair p on bits 2p and 2p+1 |
| clkOe | output | 12 | Per-output drive enable (0 = high impedance) |

## Verification
The bench builds the block with its default parameters: six pairs, X limited to 5..130 and a 9-bit divide ratio. These defaults put both clamp edges and the largest 2X ratio of 260 within reach of the 8-bit X input. The PLL stand-in runs at 6 clock cycles per period and the reference runs at 10. Divide ratios and source choice therefore show up as distinct measured periods and high times on every pair. Random tables mix all eight codes, enables, inversions and both sources. Directed cases cover the unprogrammed sets, X below 5 and above 130, and the lock tap with the flag both high and low.

// File: rtl/clkmx_pkg.sv
package clkmx_pkg;
  localparam int NUM_PAIRS = 6;
  localparam int NUM_SETS  = 4;
  localparam int CODE_W    = 3;
  localparam int NUM_TAPS  = 1 << CODE_W;
  localparam int NUM_DIVS  = 5;          // /2 /3 /4 /X /2X
  localparam int XW        = 8;
  localparam int RATIO_W   = XW + 1;

  typedef enum logic [CODE_W-1:0] {
    TAP_REF   = 3'd0,
    TAP_DIV1  = 3'd1,
    TAP_DIV2  = 3'd2,
    TAP_DIV3  = 3'd3,
    TAP_DIV4  = 3'd4,
    TAP_DIVX  = 3'd5,
    TAP_DIV2X = 3'd6,
    TAP_LOCK  = 3'd7
  } tapCode_e;

  typedef struct packed {
    logic [NUM_PAIRS-1:0]        pairEn;
    logic                        useRef;
    logic [NUM_PAIRS*CODE_W-1:0] codes;
  } cfgSet_t;

  localparam int SET_W = $bits(cfgSet_t);

  typedef struct packed {
    logic                        restart;
    logic                        useRef;
    logic [RATIO_W-1:0]          xRatio;
    logic [NUM_PAIRS-1:0]        pairEn;
    logic [NUM_PAIRS*CODE_W-1:0] codes;
  } ctrlBus_t;

  function automatic cfgSet_t factorySet(input logic [1:0] idx);
    cfgSet_t s;
    s.codes = {NUM_PAIRS{TAP_DIV2}};
    case (idx)
      2'd0: begin s.pairEn = '0;           s.useRef = 1'b0; end
      2'd1: begin s.pairEn = 6'b000111;    s.useRef = 1'b0; end
      2'd2: begin s.pairEn = '1;           s.useRef = 1'b1; end
      default: begin s.pairEn = '1;        s.useRef = 1'b0; end
    endcase
    return s;
  endfunction
endpackage

// File: rtl/clkmx_ctrl.sv
module clkmx_ctrl
  import clkmx_pkg::*;
#(
  parameter int X_MIN = 5,
  parameter int X_MAX = 130
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [1:0]                 cfgSel,
  input  logic                       cfgValid,
  input  logic [NUM_SETS*SET_W-1:0]  cfgTable,
  input  logic [XW-1:0]              xValue,
  output ctrlBus_t                   ctrlBus
);
  localparam logic [RATIO_W-1:0] RMIN = RATIO_W'(X_MIN);
  localparam logic [RATIO_W-1:0] RMAX = RATIO_W'(X_MAX);

  cfgSet_t            chosen, active;
  logic [RATIO_W-1:0] xWide, xClamp, xQ;
  logic               restartQ;

  always_comb begin
    if (cfgValid) chosen = cfgTable[cfgSel*SET_W +: SET_W];
    else          chosen = factorySet(cfgSel);
  end

  always_comb begin
    xWide = {1'b0, xValue};
    if (xWide < RMIN)      xClamp = RMIN;
    else if (xWide > RMAX) xClamp = RMAX;
    else                   xClamp = xWide;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active   <= factorySet(2'd0);
      xQ       <= RMIN;
      restartQ <= 1'b1;
    end else begin
      active   <= chosen;
      xQ       <= xClamp;
      restartQ <= (chosen != active) || (xClamp != xQ);
    end
  end

  always_comb begin
    ctrlBus.restart = restartQ;
    ctrlBus.useRef  = active.useRef;
    ctrlBus.xRatio  = xQ;
    ctrlBus.pairEn  = active.pairEn;
    ctrlBus.codes   = active.codes;
  end
endmodule

// File: rtl/clkmx_divtap.sv
module clkmx_divtap
  import clkmx_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               restart,
  input  logic               tick,
  input  logic [RATIO_W-1:0] ratio,
  output logic               tapOut
);
  logic [RATIO_W-1:0] cnt, nxt, half;
  logic               last;

  always_comb begin
    last = (cnt >= ratio - 1'b1);
    nxt  = last ? '0 : cnt + 1'b1;
    half = (ratio + 1'b1) >> 1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || restart) begin
      cnt    <= ratio - 1'b1;
      tapOut <= 1'b0;
    end else if (tick) begin
      cnt    <= nxt;
      tapOut <= (nxt < half);
    end
  end
endmodule

// File: rtl/clkmx_dpath.sv
module clkmx_dpath
  import clkmx_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   pllClk,
  input  logic                   refClk,
  input  logic                   lockFlag,
  input  logic [NUM_PAIRS-1:0]   invEven,
  input  ctrlBus_t               ctrlBus,
  output logic [NUM_TAPS-1:0]    tapVec,
  output logic [2*NUM_PAIRS-1:0] clkOut,
  output logic [2*NUM_PAIRS-1:0] clkOe
);
  logic srcLvl, srcQ, srcPrev, srcRise;
  logic refQ, refTap, div1Tap, lockTap;
  logic [RATIO_W-1:0]  ratioArr [NUM_DIVS];
  logic [NUM_DIVS-1:0] divOut;

  assign srcLvl  = ctrlBus.useRef ? refClk : pllClk;
  assign srcRise = srcQ & ~srcPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcQ <= 1'b0; srcPrev <= 1'b0; refQ <= 1'b0;
      refTap <= 1'b0; div1Tap <= 1'b0; lockTap <= 1'b0;
    end else begin
      srcQ    <= srcLvl;
      srcPrev <= srcQ;
      refQ    <= refClk;
      refTap  <= refQ;
      div1Tap <= srcQ;
      lockTap <= lockFlag;
    end
  end

  always_comb begin
    for (int g = 0; g < NUM_DIVS; g++) begin
      if (g < 3)       ratioArr[g] = RATIO_W'(g + 2);
      else if (g == 3) ratioArr[g] = ctrlBus.xRatio;
      else             ratioArr[g] = ctrlBus.xRatio << 1;
    end
  end

  for (genvar g = 0; g < NUM_DIVS; g++) begin : gDiv
    clkmx_divtap divI (
      .clk     (clk),
      .rstN    (rstN),
      .restart (ctrlBus.restart),
      .tick    (srcRise),
      .ratio   (ratioArr[g]),
      .tapOut  (divOut[g])
    );
  end

  assign tapVec = {lockTap, divOut, div1Tap, refTap};

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : gPair
    logic [CODE_W-1:0] code;
    logic              tapBit, pairOn;
    assign code   = ctrlBus.codes[p*CODE_W +: CODE_W];
    assign tapBit = tapVec[code];
    assign pairOn = ctrlBus.pairEn[p];
    always_ff @(posedge clk) begin
      if (!rstN) begin
        clkOut[2*p+1 -: 2] <= 2'b00;
        clkOe[2*p+1 -: 2]  <= 2'b00;
      end else begin
        clkOut[2*p+1] <= pairOn & tapBit;
        clkOut[2*p]   <= pairOn & (invEven[p] ? ~tapBit : tapBit);
        clkOe[2*p+1 -: 2] <= {2{pairOn}};
      end
    end
  end
endmodule

// File: rtl/clkmx_top.sv
module clkmx_top
  import clkmx_pkg::*;
#(
  parameter int X_MIN = 5,
  parameter int X_MAX = 130
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       pllClk,
  input  logic                       refClk,
  input  logic                       lockFlag,
  input  logic [1:0]                 cfgSel,
  input  logic                       cfgValid,
  input  logic [NUM_SETS*SET_W-1:0]  cfgTable,
  input  logic [NUM_PAIRS-1:0]       invEven,
  input  logic [XW-1:0]              xValue,
  output logic [2*NUM_PAIRS-1:0]     clkOut,
  output logic [2*NUM_PAIRS-1:0]     clkOe
);
  ctrlBus_t            ctrlBus;
  logic [NUM_TAPS-1:0] tapVec;

  clkmx_ctrl #(.X_MIN(X_MIN), .X_MAX(X_MAX)) ctrlI (
    .clk(clk), .rstN(rstN), .cfgSel(cfgSel), .cfgValid(cfgValid),
    .cfgTable(cfgTable), .xValue(xValue), .ctrlBus(ctrlBus)
  );

  clkmx_dpath dpathI (
    .clk(clk), .rstN(rstN), .pllClk(pllClk), .refClk(refClk),
    .lockFlag(lockFlag), .invEven(invEven), .ctrlBus(ctrlBus),
    .tapVec(tapVec), .clkOut(clkOut), .clkOe(clkOe)
  );
endmodule

// File: rtl/clkmx_chk.sv
module clkmx_chk
  import clkmx_pkg::*;
(
  input logic                   clk,
  input logic                   rstN,
  input logic                   restart,
  input logic [NUM_TAPS-1:0]    tapVec,
  input logic [NUM_PAIRS-1:0]   invEven,
  input logic [2*NUM_PAIRS-1:0] clkOut,
  input logic [2*NUM_PAIRS-1:0] clkOe
);
  // R10
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    restart |=> (tapVec[6:2] == '0));

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : gPairChk
    // R9
    oe_pair_match_chk: assert property (@(posedge clk) disable iff (!rstN)
      clkOe[2*p] == clkOe[2*p+1]);
    // R9
    off_low_chk: assert property (@(posedge clk) disable iff (!rstN)
      !clkOe[2*p] |-> (clkOut[2*p+1 -: 2] == 2'b00));
    // R6
    inv_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
      clkOe[2*p] |-> (clkOut[2*p] == ($past(invEven[p]) ? ~clkOut[2*p+1] : clkOut[2*p+1])));
  end
endmodule

bind clkmx_top clkmx_chk chkI (
  .clk(clk), .rstN(rstN), .restart(ctrlBus.restart), .tapVec(tapVec),
  .invEven(invEven), .clkOut(clkOut), .clkOe(clkOe)
);

// File: tb/clkmx_top_tb_top.sv
module clkmx_top_tb_top;
  localparam int NP = 6;
  localparam int SW = 25;
  localparam int PLL_P = 6;
  localparam int REF_P = 10;
  localparam int WATCHDOG = 190000;

  logic clk = 1'b0, rstN = 1'b0, pllClk = 1'b0, refClk = 1'b0, lockFlag = 1'b0;
  logic [1:0] cfgSel = 2'd0;
  logic cfgValid = 1'b0;
  logic [4*SW-1:0] cfgTable = '0;
  logic [NP-1:0] invEven = '0;
  logic [7:0] xValue = 8'd5;
  logic [2*NP-1:0] clkOut, clkOe;

  int vectors = 0, miscompares = 0, cyc = 0;
  bit finished = 0;
  int pc = 0, rc = 0;

  // expected configuration of the scenario
  bit eEn [NP];
  int eCode [NP];
  bit eRef;
  int eX;

  clkmx_top dut_i (
    .clk(clk), .rstN(rstN), .pllClk(pllClk), .refClk(refClk), .lockFlag(lockFlag),
    .cfgSel(cfgSel), .cfgValid(cfgValid), .cfgTable(cfgTable), .invEven(invEven),
    .xValue(xValue), .clkOut(clkOut), .clkOe(clkOe)
  );

  always #5 clk = ~clk;

  always @(negedge clk) begin
    cyc++;
    pc++; if (pc == PLL_P/2) begin pc = 0; pllClk = ~pllClk; end
    rc++; if (rc == REF_P/2) begin rc = 0; refClk = ~refClk; end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int srcPer();
    return eRef ? REF_P : PLL_P;
  endfunction

  function automatic int expPer(input int code);
    case (code)
      0: return REF_P;
      1: return srcPer();
      2, 3, 4: return code * srcPer();
      5: return eX * srcPer();
      default: return 2 * eX * srcPer();
    endcase
  endfunction

  function automatic int expHigh(input int code);
    case (code)
      0: return REF_P / 2;
      1: return srcPer() / 2;
      2, 3, 4: return ((code + 1) / 2) * srcPer();
      5: return ((eX + 1) / 2) * srcPer();
      default: return eX * srcPer();
    endcase
  endfunction

  function automatic string tapTag(input int code);
    if (code == 0) return "R2 ref tap";
    if (code == 1) return eRef ? "R2/R5 div1 on ref" : "R2 div1";
    if (code <= 4) return eRef ? "R3/R5 fixed div on ref" : "R3 fixed div";
    return eRef ? "R4/R5 X tap on ref" : "R4 X tap";
  endfunction

  // set the expected config: factory or table-derived
  task automatic loadExpect(input bit valid, input int sel, input int xv);
    if (valid) begin
      logic [SW-1:0] s;
      s = cfgTable[sel*SW +: SW];
      for (int p = 0; p < NP; p++) begin
        eEn[p] = s[19+p];
        eCode[p] = int'(s[3*p +: 3]);
      end
      eRef = s[18];
    end else begin
      for (int p = 0; p < NP; p++) begin
        eCode[p] = 2;
        eEn[p] = (sel == 0) ? 1'b0 : (sel == 1) ? (p < 3) : 1'b1;
      end
      eRef = (sel == 2);
    end
    eX = (xv < 5) ? 5 : (xv > 130) ? 130 : xv;
  endtask

  task automatic runScenario(input int sel, input bit valid, input int xv,
                             input logic [NP-1:0] inv, input bit lk);
    int lastRise [2*NP];
    int per [2*NP];
    int hi [2*NP];
    int nRise [2*NP];
    logic prev [2*NP];
    int maxPer, win, oeBad, offBad, invBad, lockBad, alignBad;
    logic [2*NP-1:0] expOe;
    @(negedge clk);
    cfgSel = 2'(sel); cfgValid = valid; xValue = 8'(xv); invEven = inv; lockFlag = lk;
    loadExpect(valid, sel, xv);
    repeat (30) @(negedge clk);
    maxPer = 20;
    for (int p = 0; p < NP; p++)
      if (eEn[p] && eCode[p] != 7 && expPer(eCode[p]) > maxPer) maxPer = expPer(eCode[p]);
    win = 2 * maxPer + 30;
    for (int i = 0; i < 2*NP; i++) begin
      lastRise[i] = -1; per[i] = 0; hi[i] = 0; nRise[i] = 0; prev[i] = clkOut[i];
    end
    for (int p = 0; p < NP; p++) expOe[2*p+1 -: 2] = {2{eEn[p]}};
    oeBad = 0; offBad = 0; invBad = 0; lockBad = 0; alignBad = 0;
    for (int t = 0; t < win; t++) begin
      @(negedge clk);
      if (clkOe !== expOe) oeBad++;
      for (int p = 0; p < NP; p++) begin
        if (!eEn[p]) begin
          if (clkOut[2*p+1 -: 2] !== 2'b00) offBad++;
        end else if (eCode[p] == 7) begin
          if (clkOut[2*p+1] !== lk || clkOut[2*p] !== (inv[p] ? ~lk : lk)) lockBad++;
        end else begin
          if (clkOut[2*p] !== (inv[p] ? ~clkOut[2*p+1] : clkOut[2*p+1])) invBad++;
          for (int q = p + 1; q < NP; q++)
            if (eEn[q] && eCode[q] == eCode[p] && clkOut[2*q+1] !== clkOut[2*p+1]) alignBad++;
        end
      end
      for (int i = 0; i < 2*NP; i++) begin
        if (clkOut[i] && !prev[i]) begin
          if (lastRise[i] >= 0) begin per[i] = cyc - lastRise[i]; nRise[i]++; end
          lastRise[i] = cyc;
        end else if (!clkOut[i] && prev[i] && lastRise[i] >= 0) begin
          hi[i] = cyc - lastRise[i];
        end
        prev[i] = clkOut[i];
      end
    end
    check(oeBad == 0, "R8 enable pattern of selected set", oeBad, 0);
    check(offBad == 0, "R9 disabled pair outputs low", offBad, 0);
    check(invBad == 0, "R6 even/odd inversion relation", invBad, 0);
    check(alignBad == 0, "R10 same-code pairs aligned", alignBad, 0);
    check(lockBad == 0, "R7 lock tap levels", lockBad, 0);
    for (int p = 0; p < NP; p++) begin
      if (eEn[p] && eCode[p] != 7) begin
        check(nRise[2*p+1] >= 1 && per[2*p+1] == expPer(eCode[p]),
              {tapTag(eCode[p]), " period"}, per[2*p+1], expPer(eCode[p]));
        check(hi[2*p+1] == expHigh(eCode[p]),
              {tapTag(eCode[p]), " high time"}, hi[2*p+1], expHigh(eCode[p]));
      end
    end
  endtask

  function automatic logic [SW-1:0] packSet(input logic [NP-1:0] en, input bit useRef,
                                            input int c0, input int c1, input int c2,
                                            input int c3, input int c4, input int c5);
    return {en, useRef, 3'(c5), 3'(c4), 3'(c3), 3'(c2), 3'(c1), 3'(c0)};
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset state
    repeat (4) @(negedge clk);
    check(clkOut === '0, "R1 clkOut during reset", int'(clkOut), 0);
    check(clkOe === '0, "R1 clkOe during reset", int'(clkOe), 0);
    rstN = 1'b1;

    // R8: unprogrammed sets, with a table present but ignored
    cfgTable = {4{packSet(6'b111111, 1'b1, 0, 1, 3, 5, 6, 7)}};
    for (int s = 0; s < 4; s++) runScenario(s, 1'b0, 9, 6'b000000, 1'b1);
    runScenario(3, 1'b0, 9, 6'b101010, 1'b0);

    // R2, R3, R4: every tap on PLL, X below range clamps to 5
    cfgTable[0*SW +: SW] = packSet(6'b111111, 1'b0, 0, 1, 2, 3, 4, 5);
    runScenario(0, 1'b1, 2, 6'b010101, 1'b0);
    // R5: same taps on reference source
    cfgTable[1*SW +: SW] = packSet(6'b111111, 1'b1, 0, 1, 2, 3, 4, 5);
    runScenario(1, 1'b1, 7, 6'b000000, 1'b0);
    // R4: 2X tap with X above range clamps to 130, R7 lock tap high and low
    cfgTable[2*SW +: SW] = packSet(6'b110111, 1'b0, 6, 7, 7, 2, 6, 5);
    runScenario(2, 1'b1, 200, 6'b000010, 1'b1);
    runScenario(2, 1'b1, 130, 6'b000100, 1'b0);
    // R9: partial enables
    cfgTable[3*SW +: SW] = packSet(6'b010010, 1'b0, 3, 3, 4, 2, 3, 1);
    runScenario(3, 1'b1, 11, 6'b111111, 1'b1);

    // random tables
    for (int r = 0; r < 8; r++) begin
      for (int s = 0; s < 4; s++) begin
        logic [NP-1:0] en;
        for (int p = 0; p < NP; p++) en[p] = ($urandom % 4) != 0;
        cfgTable[s*SW +: SW] = packSet(en, 1'($urandom % 2),
          $urandom % 8, $urandom % 8, $urandom % 8,
          $urandom % 8, $urandom % 8, $urandom % 8);
      end
      runScenario($urandom % 4, 1'b1, $urandom % 41, 6'($urandom), 1'($urandom % 2));
    end

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      finished = 1;
      vectors++; miscompares++;
      $display("FAIL watchdog expired actual=%0d expected=<%0d", WATCHDOG, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule